// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an analog-to-digital converter starts its next conversion while automatic triggering is on. A small 8-bit control register holds a 3-bit source code and a comparator-multiplexer enable bit. The source code picks one of eight candidate signals: the converter's own completion flag (free-running mode) or one of seven peripheral event flags. The picked signal passes through a single-register rising-edge detector. An edge becomes a one-cycle start pulse only if automatic triggering is enabled, the converter is enabled and no conversion is in progress.

The edge detector sits after the multiplexer. Changing the selection from a low source to a high source therefore counts as an edge. Changing the selection into free-running mode never does: the detector history is forced high for that switch. The flags are taken as already synchronous to the block clock. The asynchronous active-low reset is released through a two-stage synchronizer, so the block starts working on the third rising clock edge after reset is released.

Top module: `adc_trig_sel`

## Requirements
- R1: While reset is applied and until the internal reset releases, `reg_rdata` reads 0x00 and `start_conv` and `cmp_mux_en` are 0.
- R2: A register write stores `reg_wdata[6]` as the comparator-multiplexer enable and `reg_wdata[2:0]` as the source code. Bits 7 and 5:3 always read 0. `cmp_mux_en` equals the stored bit 6.
- R3: Source code 0 selects `conv_done`. Source code k (1 to 7) selects `evt_flags[k-1]`: comparator, external interrupt 0, timer 0 compare, timer 0 overflow, timer 1 compare B, timer 1 overflow, timer 1 capture. Unselected flags never cause a start.
- R4: A start is produced only by a low-to-high change of the selected signal, sampled at successive clock edges. `start_conv` is high for exactly one cycle, in the cycle after the edge where the high value is first sampled. A level held high gives a single start.
- R5: With `auto_en` low at the edge where the trigger edge is seen, no start is produced.
- R6: With `conv_en` low at that edge, no start is produced.
- R7: A trigger edge seen while `conv_busy` is high is discarded and is not replayed later.
- R8: A write that changes the selection from a low source to a high source (other than code 0) produces a start.
- R9: A write that changes the selection from a nonzero code to code 0 produces no start, even when `conv_done` is high.
- R10: In free-running mode each rising edge of `conv_done` produces a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| auto_en | input | 1 | Automatic triggering enable |
| conv_en | input | 1 | Converter enable |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | Converter completion flag |
| evt_flags | input | 7 | Peripheral event flags, bit k-1 for source code k |
| cmp_mux_en | output | 1 | Comparator multiplexer enable bit |
| start_conv | output | 1 | One-cycle start-conversion pulse |

## Verification
A wrong edge-history value shows at `start_conv` in the very next cycle. A stuck-low history repeats the start on every cycle the source stays high. A stuck-high history never starts at all. A corrupted source code shows on `reg_rdata` in the cycle after the write, and shows as starts from the wrong flag one cycle after that flag rises. The suppression on a switch into free-running mode is observed at `start_conv` two cycles after the write.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int CTL_W   = 8;
  localparam int CME_BIT = 6;
  localparam int SRC_W   = 3;
  localparam int NUM_SRC = 1 << SRC_W;

  typedef enum logic [SRC_W-1:0] {
    SRC_FREE    = 3'd0,
    SRC_ACMP    = 3'd1,
    SRC_EXT0    = 3'd2,
    SRC_T0_CMP  = 3'd3,
    SRC_T0_OVF  = 3'd4,
    SRC_T1_CMPB = 3'd5,
    SRC_T1_OVF  = 3'd6,
    SRC_T1_CAPT = 3'd7
  } trig_src_e;

  typedef struct packed {
    logic      cme;
    trig_src_e src;
  } trig_ctl_t;
endpackage

// File: rtl/adc_trig_rst_sync.sv
module adc_trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/adc_trig_ctl_reg.sv
module adc_trig_ctl_reg
  import adc_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output trig_ctl_t        ctl_o,
  output logic [CTL_W-1:0] rd_data,
  output logic             free_switch_o
);
  trig_ctl_t ctl_q;
  trig_ctl_t ctl_d;

  always_comb begin
    ctl_d.cme = wr_data[CME_BIT];
    ctl_d.src = trig_src_e'(wr_data[SRC_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data                = '0;
    rd_data[CME_BIT]       = ctl_q.cme;
    rd_data[SRC_W-1:0]     = ctl_q.src;
  end

  // A write moving the selection into free-running mode
  assign free_switch_o = wr_en && (ctl_d.src == SRC_FREE) && (ctl_q.src != SRC_FREE);
  assign ctl_o         = ctl_q;
endmodule

// File: rtl/adc_trig_src_mux.sv
module adc_trig_src_mux
  import adc_trig_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  trig_src_e    sel,
  input  logic         done,
  input  logic [N-2:0] flags,
  output logic         sel_o
);
  logic [N-1:0] cand;

  assign cand[0] = done;
  for (genvar g = 1; g < N; g++) begin : g_cand
    assign cand[g] = flags[g-1];
  end

  assign sel_o = cand[sel];
endmodule

// File: rtl/adc_trig_edge_gen.sv
module adc_trig_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_sig,
  input  logic hold_high,
  input  logic auto_en,
  input  logic conv_en,
  input  logic conv_busy,
  output logic start_o
);
  logic hist_q, hist_d;
  logic start_q, start_d;
  logic rise;

  always_comb begin
    rise    = sel_sig && !hist_q;
    start_d = rise && auto_en && conv_en && !conv_busy;
    hist_d  = hold_high ? 1'b1 : sel_sig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  input  logic             auto_en,
  input  logic             conv_en,
  input  logic             conv_busy,
  input  logic             conv_done,
  input  logic [NSRC-2:0]  evt_flags,
  output logic             cmp_mux_en,
  output logic             start_conv
);
  logic      rst_n_i;
  trig_ctl_t ctl;
  logic      free_switch;
  logic      sel_sig;

  adc_trig_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  adc_trig_ctl_reg i_ctl_reg (
    .clk(clk), .rst_n(rst_n_i), .wr_en(reg_we), .wr_data(reg_wdata),
    .ctl_o(ctl), .rd_data(reg_rdata), .free_switch_o(free_switch)
  );

  adc_trig_src_mux #(.N(NSRC)) i_src_mux (
    .sel(ctl.src), .done(conv_done), .flags(evt_flags), .sel_o(sel_sig)
  );

  adc_trig_edge_gen i_edge_gen (
    .clk(clk), .rst_n(rst_n_i), .sel_sig(sel_sig), .hold_high(free_switch),
    .auto_en(auto_en), .conv_en(conv_en), .conv_busy(conv_busy),
    .start_o(start_conv)
  );

  assign cmp_mux_en = ctl.cme;
endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       auto_en,
  input logic       conv_en,
  input logic       conv_busy,
  input logic       start_conv
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv); // R4
  AST_START_NEEDS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> $past(auto_en)); // R5
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> $past(conv_en)); // R6
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |-> !$past(conv_busy)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] == 1'b0) && (reg_rdata[5:3] == 3'b000)); // R2
  AST_FREE_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[2:0] == 3'b000 && reg_rdata[2:0] != 3'b000) |=> ##1 !start_conv); // R9
endmodule

bind adc_trig_sel adc_trig_sel_chk i_chk (.*);

// File: tb/test_adc_trig_sel.sv
module test_adc_trig_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       auto_en = 1'b0, conv_en = 1'b0, conv_busy = 1'b0, conv_done = 1'b0;
  logic [6:0] evt_flags = 7'h00;
  logic       cmp_mux_en, start_conv;

  int checks = 0, errors = 0, starts = 0, rs = 0;
  string cur_req = "R1";
  bit m_cme = 0, m_hist = 0, m_start = 0, finished = 0;
  int m_src = 0;

  adc_trig_sel i_adc_trig_sel (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    bit s, nh;
    if (!rst_n) begin
      rs = 0; m_cme = 0; m_src = 0; m_hist = 0; m_start = 0;
    end else if (rs < 2) begin
      rs++;
    end else begin
      s = (m_src == 0) ? conv_done : evt_flags[m_src-1];
      nh = (reg_we && reg_wdata[2:0] == 0 && m_src != 0) ? 1'b1 : s;
      m_start = s && !m_hist && auto_en && conv_en && !conv_busy;
      m_hist = nh;
      if (reg_we) begin m_cme = reg_wdata[6]; m_src = int'(reg_wdata[2:0]); end
    end
  end

  always @(posedge clk) begin
    #5;
    if (!finished) begin
      check(start_conv == m_start, cur_req, start_conv, m_start);
      check(reg_rdata == {1'b0, m_cme, 3'b000, 3'(m_src)}, cur_req, reg_rdata,
            {1'b0, m_cme, 3'b000, 3'(m_src)});
      check(cmp_mux_en == m_cme, cur_req, cmp_mux_en, m_cme);
      if (start_conv) starts++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic expect_starts(input string req, input int n);
    step(3);
    check(starts == n, req, starts, n);
    starts = 0;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    step(3);
    check(reg_rdata == 8'h00 && start_conv == 1'b0, "R1", reg_rdata, 0);
    rst_n = 1'b1;
    step(4);
    check(reg_rdata == 8'h00 && cmp_mux_en == 1'b0, "R1", reg_rdata, 0);

    cur_req = "R2";
    wr(8'hFF); step(1);
    check(reg_rdata == 8'h47, "R2", reg_rdata, 8'h47);
    check(cmp_mux_en == 1'b1, "R2", cmp_mux_en, 1);
    wr(8'h38); step(1);
    check(reg_rdata == 8'h00, "R2", reg_rdata, 8'h00);

    auto_en = 1; conv_en = 1; starts = 0;
    cur_req = "R3";
    for (int k = 1; k < 8; k++) begin
      evt_flags = 7'h00; wr(8'(k)); step(2); starts = 0;
      evt_flags = ~(7'h01 << (k - 1)); step(2); evt_flags = 7'h00; step(1);
      expect_starts("R3", 0);
      evt_flags = 7'h01 << (k - 1); step(2); evt_flags = 7'h00;
      expect_starts("R3", 1);
    end

    cur_req = "R4";
    wr(8'h03); step(2); starts = 0;
    evt_flags = 7'h04; step(10);
    expect_starts("R4", 1);
    evt_flags = 7'h00; step(2);

    cur_req = "R5";
    auto_en = 0; starts = 0;
    for (int i = 0; i < 3; i++) begin evt_flags = 7'h04; step(2); evt_flags = 7'h00; step(2); end
    expect_starts("R5", 0);
    auto_en = 1;

    cur_req = "R6";
    conv_en = 0;
    for (int i = 0; i < 3; i++) begin evt_flags = 7'h04; step(2); evt_flags = 7'h00; step(2); end
    expect_starts("R6", 0);
    conv_en = 1;

    cur_req = "R7";
    conv_busy = 1; evt_flags = 7'h04; step(2);
    conv_busy = 0; step(6);
    expect_starts("R7", 0);
    evt_flags = 7'h00; step(2);

    cur_req = "R8";
    wr(8'h01); evt_flags = 7'h02; step(3); starts = 0;
    wr(8'h02);
    expect_starts("R8", 1);
    evt_flags = 7'h00;

    cur_req = "R9";
    wr(8'h01); step(2); conv_done = 1; step(2); starts = 0;
    wr(8'h00);
    expect_starts("R9", 0);

    cur_req = "R10";
    conv_done = 0; step(2);
    for (int i = 0; i < 3; i++) begin conv_done = 1; step(2); conv_done = 0; step(3); end
    expect_starts("R10", 3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule